// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time clock. A one-cycle enable, `tick_128_i`, arrives at 128 Hz from an upstream prescaler. Each enable advances a binary sub-second divider. Stage 0 of that divider toggles at 64 Hz, and each later stage runs at half the rate of the one before it. The last stage is an extra toggle after the 1 Hz stage, so it produces a 2 s period.

Software programs a 3-bit period select. The block sets a sticky flag on each rising edge of the divider stage that the select picks. Software can also set the flag, and only software can clear it. The interrupt output follows the flag when the select holds a usable period.

All control goes through one 8-bit control byte, accessed with a single write strobe and a continuously driven read value. Bits 7:6 of the byte are reserved. Bits 5 and 4 are self-clearing strobes: one restarts the divider (adjust), and the other restarts the divider and clears the flag (reset). There is no streaming data path, so the port has no valid/ready handshake and no back-pressure. A write is taken in the cycle where `ctrl_we_i` is high at a clock edge.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After `rst_n` is asserted low, the select field is 000, the flag is 0, `ctrl_rdata_o` is 0x00 and `irq_o` is 0.
- R2: The control byte is laid out as follows. Bit 0 is the flag, bits 3:1 are the select, bit 4 is the reset strobe, bit 5 is the adjust strobe and bits 7:6 are reserved. A read returns the flag and the select, with 0 in bits 7:4. A write with either reserved bit set is ignored completely.
- R3: Each divider stage is named by the period it produces. The select codes map to stages as follows: 010 → 1/64 s, 011 → 1/16 s, 100 → 1/4 s, 101 → 1/2 s, 110 → 1 s, 111 → 2 s. These are 2, 8, 32, 64, 128 and 256 ticks. After a divider restart, the first event comes after half a period and then once every full period. The flag is set at the same clock edge that samples the tick causing the event.
- R4: Select codes 000 (off) and 001 (prohibited) never set the flag from hardware.
- R5: A write with bit 0 set to 1 sets the flag. A write with bit 0 set to 0 clears it.
- R6: Once set, the flag stays at 1 through any number of further ticks until software clears it.
- R7: A period event and a write that clears the flag in the same cycle leave the flag at 1.
- R8: A write with the reset strobe set clears the flag and restarts the divider. It overrides both a period event and a written flag value of 1 in the same cycle. The strobe always reads back as 0.
- R9: A write with the adjust strobe set restarts the divider. The strobe always reads back as 0.
- R10: `irq_o` is 1 exactly when the flag is 1 and the select is one of 010 to 111.
- R11: The divider advances only on `tick_128_i`. A select change without a strobe does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_128_i | input | 1 | 128 Hz one-cycle enable for the divider |
| ctrl_we_i | input | 1 | Write strobe for the control byte |
| ctrl_wdata_i | input | 8 | Value written to the control byte |
| ctrl_rdata_o | output | 8 | Current control byte read value |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The bench runs each valid select code right after an adjust restart and measures both the half-period first event and the full-period spacing of later events. An off-by-one in the stage mapping or the edge detection changes which tick sets the flag. Long tick runs with codes 000 and 001 show that no hardware events occur, and a long run with the flag already set shows that it stays sticky. Single-cycle collisions separate the priorities of the flag: event against a clearing write, and reset strobe against event plus a setting write. A mid-count select change separates a divider that keeps running from one that restarts.

// File: rtl/rpi_pkg.sv
package rpi_pkg;

  typedef enum logic [2:0] {
    SEL_OFF   = 3'b000,
    SEL_BAD   = 3'b001,
    SEL_P64   = 3'b010,
    SEL_P16   = 3'b011,
    SEL_P4    = 3'b100,
    SEL_P2    = 3'b101,
    SEL_P1    = 3'b110,
    SEL_PHALF = 3'b111
  } per_sel_e;

  localparam int CTRL_W   = 8;
  localparam int FLAG_BIT = 0;
  localparam int SEL_LSB  = 1;
  localparam int SEL_W    = 3;
  localparam int RST_BIT  = 4;
  localparam int ADJ_BIT  = 5;
  localparam int RSV_LSB  = 6;
  localparam int RSV_W    = CTRL_W - RSV_LSB;

  // Minimum divider depth: stage 7 is the 2 s toggle.
  localparam int MIN_STAGES = 8;

  function automatic logic sel_usable(per_sel_e s);
    return (s != SEL_OFF) && (s != SEL_BAD);
  endfunction

endpackage

// File: rtl/rpi_divider.sv
module rpi_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [DIV_W-1:0] rise_o
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // A stage rises when all lower stages are 1, it is 0, and a tick lands.
  generate
    for (genvar i = 0; i < DIV_W; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign rise_o[i] = tick_i & ~clr_i & ~cnt_q[0];
      end else begin : g_next
        assign rise_o[i] = tick_i & ~clr_i & (&cnt_q[i-1:0]) & ~cnt_q[i];
      end
    end
  endgenerate

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rpi_period_sel.sv
module rpi_period_sel
  import rpi_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  per_sel_e         sel_i,
  input  logic [DIV_W-1:0] rise_i,
  output logic             event_o
);

  always_comb begin
    case (sel_i)
      SEL_P64:   event_o = rise_i[0];
      SEL_P16:   event_o = rise_i[2];
      SEL_P4:    event_o = rise_i[4];
      SEL_P2:    event_o = rise_i[5];
      SEL_P1:    event_o = rise_i[6];
      SEL_PHALF: event_o = rise_i[7];
      default:   event_o = 1'b0;
    endcase
  end

  a_r4_no_event_when_unusable: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_usable(sel_i) |-> !event_o);

  a_r3_event_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (rise_i != '0));

endmodule

// File: rtl/rpi_ctrl_reg.sv
module rpi_ctrl_reg
  import rpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              event_i,
  output per_sel_e          sel_o,
  output logic              flag_o,
  output logic              div_clr_o,
  output logic [CTRL_W-1:0] rdata_o
);

  logic     wr_ok;
  logic     rst_req;
  per_sel_e sel_q;
  logic     flag_q;

  assign wr_ok     = we_i && (wdata_i[RSV_LSB +: RSV_W] == '0);
  assign rst_req   = wr_ok && wdata_i[RST_BIT];
  assign div_clr_o = wr_ok && (wdata_i[RST_BIT] || wdata_i[ADJ_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_OFF;
      flag_q <= 1'b0;
    end else begin
      if (wr_ok) sel_q <= per_sel_e'(wdata_i[SEL_LSB +: SEL_W]);
      if (rst_req)      flag_q <= 1'b0;
      else if (event_i) flag_q <= 1'b1;
      else if (wr_ok)   flag_q <= wdata_i[FLAG_BIT];
    end
  end

  assign sel_o   = sel_q;
  assign flag_o  = flag_q;
  assign rdata_o = {{(CTRL_W - SEL_LSB - SEL_W){1'b0}}, sel_q, flag_q};

  a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> flag_q);

  a_r6_clear_only_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_ok && (!wdata_i[FLAG_BIT] || wdata_i[RST_BIT])));

  a_r5_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(event_i || (wr_ok && wdata_i[FLAG_BIT])));

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rpi_pkg::*;
#(
  parameter int DIV_W = 8  // at least MIN_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_128_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic              irq_o
);

  localparam int STAGES = (DIV_W < MIN_STAGES) ? MIN_STAGES : DIV_W;

  logic [STAGES-1:0] rise;
  logic              div_clr;
  logic              period_evt;
  per_sel_e          sel;
  logic              flag;

  rpi_divider #(.DIV_W(STAGES)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_128_i),
    .clr_i  (div_clr),
    .rise_o (rise)
  );

  rpi_period_sel #(.DIV_W(STAGES)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel),
    .rise_i  (rise),
    .event_o (period_evt)
  );

  rpi_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .event_i   (period_evt),
    .sel_o     (sel),
    .flag_o    (flag),
    .div_clr_o (div_clr),
    .rdata_o   (ctrl_rdata_o)
  );

  assign irq_o = flag && sel_usable(sel);

  a_r10_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata_o[0] && ctrl_rdata_o[3:1] >= 3'b010) |-> irq_o);

endmodule

// File: tb/rtc_periodic_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_periodic_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  string      q_tag[$];
  logic       q_irq[$];
  logic [7:0] q_rd[$];

  int       m_cnt = 0;
  bit       m_flag = 1'b0;
  bit [2:0] m_sel = 3'b000;

  always #2 clk = ~clk;

  rtc_periodic_irq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_128_i   (tick),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (rdata),
    .irq_o        (irq)
  );

  function automatic int half_ticks(bit [2:0] s);
    case (s)
      3'd2:    return 1;
      3'd3:    return 4;
      3'd4:    return 16;
      3'd5:    return 32;
      3'd6:    return 64;
      3'd7:    return 128;
      default: return 0;
    endcase
  endfunction

  task automatic push_exp(string tag);
    q_tag.push_back(tag);
    q_irq.push_back(m_flag && (m_sel >= 3'd2));
    q_rd.push_back({4'b0000, m_sel, m_flag});
  endtask

  // Driver: applies one cycle of stimulus, advances the model, queues the result.
  task automatic cyc(bit w, bit [7:0] b, bit tk, string tag);
    bit ok, clr, ev;
    int nc, h;
    we = w; wdata = b; tick = tk;
    @(posedge clk); #1;
    we = 1'b0; wdata = 8'h00; tick = 1'b0;
    ok  = w && (b[7:6] == 2'b00);
    clr = ok && (b[4] || b[5]);
    ev  = 1'b0;
    h   = half_ticks(m_sel);
    if (tk && !clr && h != 0) begin
      nc = (m_cnt + 1) % 256;
      ev = ((nc % (2 * h)) == h);
    end
    if (clr)     m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1) % 256;
    if (ok && b[4]) m_flag = 1'b0;
    else if (ev)    m_flag = 1'b1;
    else if (ok)    m_flag = b[0];
    if (ok) m_sel = b[3:1];
    push_exp(tag);
  endtask

  task automatic wr(bit [7:0] b, string tag);
    cyc(1'b1, b, 1'b0, tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, tag);
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q_tag.size() > 0) begin
      string t;
      logic ei;
      logic [7:0] er;
      t  = q_tag.pop_front();
      ei = q_irq.pop_front();
      er = q_rd.pop_front();
      n_chk++;
      if (rdata !== er || irq !== ei) begin
        n_fail++;
        $display("FAIL %s: rdata=%02h irq=%b expected rdata=%02h irq=%b",
                 t, rdata, irq, er, ei);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push_exp("R1");

    // R9 adjust restart with code 010, then R3 spacing of 2 ticks
    wr(8'h24, "R9");
    ticks(1, "R3");
    wr(8'h04, "R5");
    ticks(2, "R3");

    // R3 each remaining code: half-period first event, full period after
    for (int s = 3; s < 8; s++) begin
      int h;
      h = half_ticks(3'(s));
      wr(8'(8'h20 | (s << 1)), "R9");
      ticks(h - 1, "R3");
      ticks(1, "R3");
      wr(8'(s << 1), "R5");
      ticks(2 * h - 1, "R3");
      ticks(1, "R3");
    end

    // R6 flag held through many ticks
    ticks(300, "R6");

    // R11 select change mid-count keeps the divider running
    wr(8'h26, "R11");
    ticks(3, "R11");
    wr(8'h0A, "R11");
    ticks(29, "R11");

    // R4 off and prohibited codes
    wr(8'h20, "R4");
    ticks(300, "R4");
    wr(8'h22, "R4");
    ticks(300, "R4");

    // R10 and R5 software set with various codes
    wr(8'h01, "R10");
    wr(8'h03, "R10");
    wr(8'h0D, "R10");
    wr(8'h0C, "R5");

    // R7 event against clearing write
    wr(8'h24, "R7");
    cyc(1'b1, 8'h04, 1'b1, "R7");

    // R8 reset strobe against event and setting write
    wr(8'h25, "R8");
    cyc(1'b1, 8'h15, 1'b1, "R8");
    ticks(1, "R8");

    // R2 reserved bits block the write
    wr(8'h80, "R2");
    wr(8'h41, "R2");
    wr(8'h0E, "R2");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule